// File: doc/BRIEF.md
# External Memory Port Hold Controller

This block decides when a processor hands its external memory port to another bus master. A request can arrive on an active-low hold pin from outside the chip, or it can come from software through an internal-hold control bit. A mask bit lets software keep the bus and ignore the pin. The internal hold still works while the mask is set.

The external request is asynchronous. It passes through a two-flop synchronizer before it takes part in arbitration. A hold is granted only in a cycle where the memory interface reports no bus cycle in progress. In the cycle the grant takes effect, the port drivers go to high impedance and the active-low acknowledge goes low together. The hold ends on the clock edge after the last active source goes away.

A small control register holds three bits. Bit 0 is the read-only hold status. Bit 1 is the mask. Bit 2 is the internal-hold bit. Software writes bits 1 and 2 with a single-cycle write strobe.

Top module: `port_hold_ctrl`

## Requirements
- R1: After reset, `hold_ack_n` is 1, `bus_hiz` is 0, and all three bits of `cfg_rdata` are 0.
- R2: With the mask at 0 and no bus cycle in progress, a low level on `hold_req_n` is reflected in the synchronizer on the first and second rising edges. On the third rising edge `hold_ack_n` goes to 0 and `bus_hiz` goes to 1.
- R3: While the mask bit (`cfg_rdata[1]`) is 1, a low `hold_req_n` never asserts `hold_ack_n` and never sets `bus_hiz`.
- R4: Setting the internal-hold bit (`cfg_rdata[2]`) requests hold in the same way as the pin. The grant takes effect on the edge after the bit is written, and this holds whether the mask is 0 or 1.
- R5: No grant is given on any edge where `cycle_busy` is 1. Once granted, the hold persists regardless of `cycle_busy` for as long as any source remains active.
- R6: When every active source has gone away, the hold ends on the next rising edge. At that edge `hold_ack_n` returns to 1, `bus_hiz` returns to 0 and the status bit clears. For the pin, the source goes away once the synchronizer shows it released (two edges).
- R7: A write with `cfg_wr` = 1 loads `cfg_wdata[1]` into the mask and `cfg_wdata[2]` into the internal-hold bit. `cfg_wdata[0]` is ignored. The status bit `cfg_rdata[0]` reads 1 exactly while the port is held, whatever the source of the hold.
- R8: `hold_ack_n` is always the inverse of `bus_hiz`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_n | input | 1 | External hold request, active low, asynchronous |
| cycle_busy | input | 1 | An external bus cycle is in progress |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Write data: bit 2 internal hold, bit 1 mask, bit 0 ignored |
| cfg_rdata | output | 3 | Read data: bit 2 internal hold, bit 1 mask, bit 0 hold status |
| hold_ack_n | output | 1 | Hold acknowledge, active low |
| bus_hiz | output | 1 | 1 puts the port drivers in high impedance |

## Verification
The embedded assertions check four behaviours on every cycle. No grant is taken during a busy cycle. A masked pin alone never grants. An internal hold is granted as soon as the bus is idle. A hold ends or stays exactly as its sources dictate. The exact three-edge latency through the synchronizer can only be shown by the bench's scenarios. The same applies to the register write behaviour, the ignored status bit and the ordering of mask and internal hold in a mixed sequence.

// File: rtl/port_hold_ctrl.sv
module port_hold_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_req_n,
  input  logic       cycle_busy,
  input  logic       cfg_wr,
  input  logic [2:0] cfg_wdata,
  output logic [2:0] cfg_rdata,
  output logic       hold_ack_n,
  output logic       bus_hiz
);

  logic sync_q1, sync_q2;
  logic mask_q, int_hold_q, held_q;
  logic want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
    end else begin
      sync_q1 <= ~hold_req_n;
      sync_q2 <= sync_q1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= 1'b0;
      int_hold_q <= 1'b0;
    end else if (cfg_wr) begin
      mask_q     <= cfg_wdata[1];
      int_hold_q <= cfg_wdata[2];
    end
  end

  assign want = int_hold_q | (sync_q2 & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      held_q <= 1'b0;
    else if (held_q)
      held_q <= want;
    else
      held_q <= want & ~cycle_busy;
  end

  assign bus_hiz    = held_q;
  assign hold_ack_n = ~held_q;
  assign cfg_rdata  = {int_hold_q, mask_q, held_q};

  assert_no_grant_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_hiz && cycle_busy) |=> !bus_hiz);

  assert_hold_persists_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hiz && (int_hold_q || (sync_q2 && !mask_q))) |=> bus_hiz);

  assert_mask_blocks_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_hiz && mask_q && !int_hold_q) |=> !bus_hiz);

  assert_internal_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_hold_q && !cycle_busy) |=> (bus_hiz && !hold_ack_n));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hiz && !int_hold_q && !(sync_q2 && !mask_q)) |=> (!bus_hiz && hold_ack_n && !cfg_rdata[0]));

endmodule

// File: tb/port_hold_ctrl_tb.sv
module port_hold_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hold_req_n = 1'b1;
  logic       cycle_busy = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_wdata = 3'b000;
  logic [2:0] cfg_rdata;
  logic       hold_ack_n, bus_hiz;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  port_hold_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .cycle_busy(cycle_busy),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .hold_ack_n(hold_ack_n), .bus_hiz(bus_hiz)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_held(input string req, input logic h);
    chk(req, {5'd0, hold_ack_n, bus_hiz, cfg_rdata[0]}, {5'd0, ~h, h, h});
    chk("R8", {7'd0, hold_ack_n ^ bus_hiz}, 8'd1);
  endtask

  task automatic write_cfg(input logic [2:0] d);
    cfg_wr = 1'b1; cfg_wdata = d;
    tick(1);
    cfg_wr = 1'b0; cfg_wdata = 3'b000;
  endtask

  task automatic t_reset;
    chk("R1 rdata", {5'd0, cfg_rdata}, 8'd0);
    chk_held("R1", 1'b0);
  endtask

  task automatic t_pin_hold;
    hold_req_n = 1'b0;
    tick(2);
    chk_held("R2 before third edge", 1'b0);
    tick(1);
    chk_held("R2 granted", 1'b1);
    chk("R7 status", {7'd0, cfg_rdata[0]}, 8'd1);
    hold_req_n = 1'b1;
    tick(2);
    chk_held("R6 still held", 1'b1);
    tick(1);
    chk_held("R6 released", 1'b0);
  endtask

  task automatic t_busy;
    cycle_busy = 1'b1;
    hold_req_n = 1'b0;
    tick(6);
    chk_held("R5 no grant while busy", 1'b0);
    cycle_busy = 1'b0;
    tick(1);
    chk_held("R5 grant after busy", 1'b1);
    cycle_busy = 1'b1;
    tick(2);
    chk_held("R5 held despite busy", 1'b1);
    cycle_busy = 1'b0;
    hold_req_n = 1'b1;
    tick(3);
    chk_held("R6 released after busy test", 1'b0);
  endtask

  task automatic t_mask_and_internal;
    write_cfg(3'b010);
    chk("R7 mask write", {5'd0, cfg_rdata}, 8'b010);
    hold_req_n = 1'b0;
    tick(6);
    chk_held("R3 masked pin", 1'b0);
    write_cfg(3'b110);
    chk("R7 int write", {5'd0, cfg_rdata}, 8'b110);
    tick(1);
    chk_held("R4 internal grant with mask", 1'b1);
    hold_req_n = 1'b1;
    tick(3);
    write_cfg(3'b000);
    chk_held("R6 one edge after clear", 1'b1);
    tick(1);
    chk_held("R6 internal release", 1'b0);
  endtask

  task automatic t_internal_nomask;
    write_cfg(3'b100);
    chk_held("R4 not yet", 1'b0);
    tick(1);
    chk_held("R4 internal grant", 1'b1);
    write_cfg(3'b000);
    tick(1);
    chk_held("R6 released", 1'b0);
  endtask

  task automatic t_status_ro;
    write_cfg(3'b001);
    tick(2);
    chk("R7 status ignored", {5'd0, cfg_rdata}, 8'd0);
    chk_held("R7 no hold", 1'b0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_pin_hold();
    t_busy();
    t_mask_and_internal();
    t_internal_nomask();
    t_status_ro();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule